// File: doc/BRIEF.md
# Serial Converter Command and Result Port

This block is the digital side of a multichannel successive-approximation converter's host link. A host selects the device by pulling chip select low, toggles a serial clock and supplies command bits on a serial input. During that same frame the block shifts out, on a serial output, the result of the conversion that the previous frame started. The first four command bits pick the channel to convert next. They reach the multiplexer select output early, so that the sample window can open on the fourth falling clock edge. The last four bits are configuration.

On the twelfth falling serial-clock edge the frame ends. The block closes the sample window and pulses a start strobe to a conversion engine. That engine is outside this block. It answers with a done pulse and a 12-bit result. A status pin reports progress. It works either as an end-of-conversion flag, low while the conversion is busy, or as an interrupt, which goes low once data is ready and is cleared by the next serial-clock rise. All pins are sampled in one fast system clock domain through two-stage synchronizers.

Top module: `serial_adc_link`

## Requirements
- R1: After reset `statusN` is 1, `sampleEn` is 0 and `sdoOe` is 0. `sdoOe` is 1 only while chip select is low, and it falls within a few system clocks of chip select rising.
- R2: When chip select falls, `sdo` shows the first bit of the stored result. Each falling serial-clock edge advances `sdo` by one bit, so twelve bits are shown in total. After reset the stored result is zero.
- R3: Configuration bit 0 is the last command bit shifted in. A 1 there makes the following frame's output LSB-first; a 0 makes it MSB-first. After reset the output is MSB-first.
- R4: Command bits are captured MSB first on the first eight rising serial-clock edges. Rising edges after the eighth in a frame are ignored.
- R5: `chanSel` takes the first four command bits, with the first bit as its MSB, right after the fourth rising edge. It then holds that value until the fourth rising edge of a later frame.
- R6: `sampleEn` rises after the fourth falling serial-clock edge and falls after the twelfth.
- R7: `convStart` is a single-cycle pulse issued after the twelfth falling edge. The `convResult` value present with the `convDone` that answers it becomes the next stored result.
- R8: With configuration bit 1 equal to 0 (end-of-conversion mode), `statusN` goes low at `convStart` and returns high on `convDone`.
- R9: With configuration bit 1 equal to 1 (interrupt mode), `statusN` stays high during the conversion. It goes low on `convDone` and goes high again on the next rising serial-clock edge while chip select is low.
- R10: If chip select rises before the twelfth falling edge, the frame is aborted. `sampleEn` drops, no `convStart` is issued, and the stored result and configuration are left as they were.
- R11: Serial-clock edges while chip select is high have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command input |
| sdo | output | 1 | Serial result output, meaningful while `sdoOe` is 1 |
| sdoOe | output | 1 | Output enable for `sdo`; the pad is high-impedance when it is 0 |
| chanSel | output | 4 | Channel select for the analog multiplexer |
| sampleEn | output | 1 | Sample window for the capacitor array |
| convStart | output | 1 | One-cycle conversion start strobe |
| convDone | input | 1 | Conversion complete pulse |
| convResult | input | 12 | Conversion result, valid with `convDone` |
| statusN | output | 1 | Status pin, end-of-conversion or interrupt, active low |

## Verification
A bit counter that is off by one shows up within the same frame. The result leaves on `sdo` rotated by a bit, `chanSel` changes one serial clock early or late, and the `sampleEn` window has the wrong edges, all seen a few system clocks after the serial edge concerned. A wrong status mode, or a lost busy flag, shows on `statusN` during the next conversion or at the next frame's first rising edge. A corrupted stored result or configuration stays hidden until the following frame, where every shifted bit is compared against the value the bench supplied one frame earlier.

// File: rtl/serial_adc_pkg.sv
package serial_adc_pkg;
  // Strobes from control to datapath, each valid for one system clock
  typedef struct packed {
    logic loadOut;    // chip select fell: load output shifter
    logic shiftOut;   // serial falling edge: next output bit
    logic takeBit;    // serial rising edge inside command window
    logic latchAddr;  // this rising edge completes the address
    logic latchCfg;   // this rising edge completes the configuration
    logic takeResult; // conversion finished: store result
  } strobe_t;
endpackage

// File: rtl/serial_adc_sync.sv
module serial_adc_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] async,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= RST_VAL;
    else       chain[0] <= async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= RST_VAL;
      else       chain[s] <= chain[s-1];
    end
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl
  import serial_adc_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CMD_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csS,
  input  logic    sclkS,
  input  logic    intMode,
  input  logic    convDone,
  output strobe_t strb,
  output logic    frameActive,
  output logic    sampleEn,
  output logic    convStart,
  output logic    statusN
);
  localparam int CW = $clog2(RES_W + 1);

  logic          csPrev, sclkPrev;
  logic          csFall, csRise, sclkRise, sclkFall;
  logic [CW-1:0] riseCnt, fallCnt;
  logic          busy, convInt;

  assign csFall   = csPrev && !csS;
  assign csRise   = !csPrev && csS;
  assign sclkRise = !csS && !sclkPrev && sclkS;
  assign sclkFall = !csS && sclkPrev && !sclkS;

  always_comb begin
    strb            = '0;
    strb.loadOut    = csFall;
    strb.takeBit    = sclkRise && (riseCnt < CW'(CMD_W));
    strb.latchAddr  = strb.takeBit && (riseCnt == CW'(ADDR_W - 1));
    strb.latchCfg   = strb.takeBit && (riseCnt == CW'(CMD_W - 1));
    strb.shiftOut   = sclkFall && (fallCnt < CW'(RES_W - 1));
    strb.takeResult = convDone && busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev      <= 1'b1;
      sclkPrev    <= 1'b0;
      riseCnt     <= '0;
      fallCnt     <= '0;
      frameActive <= 1'b0;
      sampleEn    <= 1'b0;
      convStart   <= 1'b0;
    end else begin
      csPrev    <= csS;
      sclkPrev  <= sclkS;
      convStart <= 1'b0;
      if (csFall) begin
        riseCnt     <= '0;
        fallCnt     <= '0;
        frameActive <= 1'b1;
        sampleEn    <= 1'b0;
      end else if (csRise) begin
        frameActive <= 1'b0;
        sampleEn    <= 1'b0;
      end else begin
        if (strb.takeBit) riseCnt <= riseCnt + 1'b1;
        if (sclkFall && fallCnt < CW'(RES_W)) begin
          fallCnt <= fallCnt + 1'b1;
          if (fallCnt == CW'(ADDR_W - 1)) sampleEn <= 1'b1;
          if (fallCnt == CW'(RES_W - 1)) begin
            sampleEn  <= 1'b0;
            convStart <= 1'b1;
          end
        end
      end
    end
  end

  // Conversion hand-off and status pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      convInt <= 1'b0;
      statusN <= 1'b1;
    end else begin
      if (convStart) begin
        busy    <= 1'b1;
        convInt <= intMode;
        if (!intMode) statusN <= 1'b0;
      end else if (strb.takeResult) begin
        busy    <= 1'b0;
        statusN <= !convInt;
      end else if (sclkRise && convInt && !busy) begin
        statusN <= 1'b1;
      end
    end
  end

  assert_oe_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> !frameActive);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    fallCnt <= CW'(RES_W));
  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  assert_window_close_R6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !sampleEn);
  assert_eoc_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !intMode) |=> !statusN);
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> (!sampleEn && !convStart));
endmodule

// File: rtl/serial_adc_dp.sv
module serial_adc_dp
  import serial_adc_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              dinS,
  input  logic [RES_W-1:0]  convResult,
  output logic              sdo,
  output logic [ADDR_W-1:0] chanSel,
  output logic              intMode
);
  localparam int SH_W = ADDR_W - 1;

  logic [RES_W-1:0]  resultReg, outShift, resultRev;
  logic [SH_W-1:0]   inShift;
  logic [ADDR_W-1:0] nextIn;
  logic              lsbFirst;

  assign nextIn = {inShift, dinS};

  for (genvar i = 0; i < RES_W; i++) begin : gRev
    assign resultRev[i] = resultReg[RES_W-1-i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      outShift  <= '0;
      inShift   <= '0;
      chanSel   <= '0;
      lsbFirst  <= 1'b0;
      intMode   <= 1'b0;
    end else begin
      if (strb.takeResult) resultReg <= convResult;
      if (strb.loadOut)       outShift <= lsbFirst ? resultRev : resultReg;
      else if (strb.shiftOut) outShift <= {outShift[RES_W-2:0], 1'b0};
      if (strb.takeBit)   inShift <= nextIn[SH_W-1:0];
      if (strb.latchAddr) chanSel <= nextIn;
      if (strb.latchCfg) begin
        lsbFirst <= nextIn[0];
        intMode  <= nextIn[1];
      end
    end
  end

  assign sdo = outShift[RES_W-1];

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchAddr |=> $stable(chanSel));
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.takeResult |=> $stable(resultReg));
endmodule

// File: rtl/serial_adc_link.sv
module serial_adc_link
  import serial_adc_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CMD_W = 8,
  parameter int ADDR_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  output logic [ADDR_W-1:0] chanSel,
  output logic              sampleEn,
  output logic              convStart,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              statusN
);
  strobe_t strb;
  logic    csS, sclkS, dinS, intMode;

  serial_adc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) syncI (
    .clk(clk), .rstN(rstN), .async({csN, sclk, sdi}), .synced({csS, sclkS, dinS})
  );

  serial_adc_ctrl #(.RES_W(RES_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W)) ctrlI (
    .clk(clk), .rstN(rstN), .csS(csS), .sclkS(sclkS), .intMode(intMode),
    .convDone(convDone), .strb(strb), .frameActive(sdoOe), .sampleEn(sampleEn),
    .convStart(convStart), .statusN(statusN)
  );

  serial_adc_dp #(.RES_W(RES_W), .ADDR_W(ADDR_W)) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .dinS(dinS), .convResult(convResult),
    .sdo(sdo), .chanSel(chanSel), .intMode(intMode)
  );
endmodule

// File: tb/serial_adc_link_tb.sv
module serial_adc_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;     // system clocks per serial half period
  localparam int SETTLE = 6;    // system clocks from pin change to sampling
  localparam int LATENCY = 20;  // conversion time in system clocks

  logic clk = 0, rstN = 0, csN = 1, sclk = 0, sdi = 0;
  logic sdo, sdoOe, sampleEn, convStart, statusN;
  logic [3:0] chanSel;
  logic convDone = 0;
  logic [11:0] convResult = '0;

  int tests = 0, fails = 0, starts = 0;
  bit finished = 0;
  logic [11:0] pendingResult = '0;
  bit expQ[$];
  string curTag = "R2";
  event sampleEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_adc_link dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdoOe(sdoOe), .chanSel(chanSel), .sampleEn(sampleEn), .convStart(convStart),
    .convDone(convDone), .convResult(convResult), .statusN(statusN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Conversion engine model
  initial forever begin
    @(negedge clk);
    if (convStart) begin
      starts++;
      repeat (LATENCY) @(negedge clk);
      convResult = pendingResult;
      convDone = 1;
      @(negedge clk);
      convDone = 0;
    end
  end

  // Scoreboard monitor for output bits
  initial forever begin
    @(sampleEv);
    if (expQ.size() == 0) check(0, curTag, 0, 1);
    else begin
      bit e;
      e = expQ.pop_front();
      check(sdoOe === 1'b1 && sdo === e, curTag, int'(sdo), int'(e));
    end
  end

  // One complete frame; the driver pushes the expected output bits first
  task automatic doFrame(input logic [7:0] cmd, input logic [11:0] prevRes,
                         input bit prevLsb, input bit intClr, input logic [11:0] nextRes);
    pendingResult = nextRes;
    curTag = prevLsb ? "R3" : "R2";
    for (int b = 0; b < 12; b++) expQ.push_back(prevLsb ? prevRes[b] : prevRes[11-b]);
    csN = 0;
    clks(SETTLE);
    check(sdoOe === 1'b1, "R1", int'(sdoOe), 1);
    -> sampleEv;
    clks(HALF - SETTLE);
    for (int k = 1; k <= 12; k++) begin
      sdi = (k <= 8) ? cmd[8-k] : 1'b0;
      clks(2);
      sclk = 1;
      clks(SETTLE);
      if (k == 1 && intClr) check(statusN === 1'b1, "R9", int'(statusN), 1);
      if (k == 4) check(chanSel === cmd[7:4], "R5", int'(chanSel), int'(cmd[7:4]));
      clks(HALF - SETTLE);
      sclk = 0;
      clks(SETTLE);
      if (k < 12) -> sampleEv;
      check(sampleEn === (k >= 4 && k < 12), "R6", int'(sampleEn), int'(k >= 4 && k < 12));
      if (k == 12) begin
        check(statusN === cmd[1], cmd[1] ? "R9" : "R8", int'(statusN), int'(cmd[1]));
        check(chanSel === cmd[7:4], "R4", int'(chanSel), int'(cmd[7:4]));
      end
      clks(HALF - SETTLE - 2);
    end
    csN = 1;
    clks(SETTLE);
    check(sdoOe === 1'b0, "R1", int'(sdoOe), 0);
    clks(40);
    check(statusN === !cmd[1], cmd[1] ? "R9" : "R8", int'(statusN), int'(!cmd[1]));
  endtask

  initial begin
    int st;
    clks(3);
    check(statusN === 1'b1 && sampleEn === 1'b0 && sdoOe === 1'b0, "R1",
          int'({statusN, sampleEn, sdoOe}), 3'b100);
    rstN = 1;
    clks(5);
    doFrame(8'h50, 12'h000, 0, 0, 12'hA5C);
    check(starts == 1, "R7", starts, 1);
    doFrame(8'h31, 12'hA5C, 0, 0, 12'h3C1);
    doFrame(8'hC2, 12'h3C1, 1, 0, 12'h801);
    doFrame(8'h70, 12'h801, 0, 1, 12'h5F3);
    check(starts == 4, "R7", starts, 4);
    // Aborted frame: two serial clocks, then chip select rises
    st = starts;
    csN = 0;
    clks(HALF);
    for (int k = 0; k < 2; k++) begin
      sdi = 1; sclk = 1; clks(HALF); sclk = 0; clks(HALF);
    end
    csN = 1;
    clks(SETTLE);
    check(sampleEn === 1'b0 && sdoOe === 1'b0, "R10", int'({sampleEn, sdoOe}), 0);
    // Serial clock toggling while deselected
    for (int k = 0; k < 6; k++) begin
      sclk = 1; clks(HALF); sclk = 0; clks(HALF);
    end
    check(chanSel === 4'h7 && sdoOe === 1'b0 && sampleEn === 1'b0, "R11",
          int'(chanSel), 7);
    check(starts == st, "R10", starts, st);
    check(statusN === 1'b1, "R11", int'(statusN), 1);
    doFrame(8'hE0, 12'h5F3, 0, 0, 12'h0FF);
    check(chanSel === 4'hE, "R5", int'(chanSel), 14);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule